// File: doc/BRIEF.md
# Dual-Clock FIFO with Thirty-Three Entries

This block moves words from one clock domain to another through a queue that holds exactly thirty-three entries. A thirty-two-entry core, addressed by Gray-coded pointers that cross between the domains, is followed by a single holding register on the read side. Neither part needs an odd-length Gray cycle, and no thirty-fourth word of storage exists.

The producer presents a word with a write strobe and watches a full flag in its own clock domain. The consumer watches an empty flag and a data output, and pulses a read strobe to take the word on show, all in the read clock domain. Whenever the holding register is vacant and the core has a word, the register takes that word from the core, so the output always shows the oldest word in the queue. Each domain has its own active-low asynchronous reset.

Top module: `odd_depth_afifo`

## Requirements
- R1: With no reads, exactly 33 writes are accepted. A further write is refused.
- R2: Words leave the queue in the order in which they were accepted, and every accepted word is delivered.
- R3: A write strobe while `wrFull` is high stores nothing and does not disturb any word already held.
- R4: A read strobe while `rdEmpty` is high has no effect. The next word written is still the next word delivered.
- R5: After reset, `rdEmpty` is 1 and `wrFull` is 0.
- R6: While `rdEmpty` is low, `rdData` shows the oldest held word. With no read strobe, that word and the low `rdEmpty` stay unchanged on the next read clock.
- R7: Flags never clear early. `wrFull` is high whenever 33 words are held, and `rdEmpty` is high whenever no word is held. Each pointer that crosses domains changes by at most one bit per clock.
- R8: With no reads, `wrFull` stays high once it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-domain clock |
| wrRstN | input | 1 | Write-domain asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Word to write |
| wrFull | output | 1 | Queue full, in the write domain |
| rdClk | input | 1 | Read-domain clock |
| rdRstN | input | 1 | Read-domain asynchronous reset, active low |
| rdEn | input | 1 | Read strobe; takes the word shown on `rdData` |
| rdData | output | DATA_W | Oldest held word |
| rdEmpty | output | 1 | No word held, in the read domain |

## Verification
`wrFull` is computed without a register from the write pointer and the synchronized read pointer. It can therefore rise at the write-clock edge that takes the word that fills the queue. `rdData` and `rdEmpty` change only at read-clock edges. A newly written word reaches the output after two synchronizer edges plus one load edge in the read domain. The bench drives and samples each domain at the falling edge of that domain's own clock, so every sample sees the settled result of the previous rising edge. Because the domains are unrelated, crossing delays vary, and the bench does not demand exact arrival cycles for them. It checks instead that a flag is never released early, that the word on show always matches the head of the reference queue, and that held output stays steady between reads.

// File: rtl/odd_depth_afifo_pkg.sv
package odd_depth_afifo_pkg;

  // Strobes from control to datapath. memWrite is in the write domain;
  // holdLoad is in the read domain.
  typedef struct packed {
    logic memWrite;
    logic holdLoad;
  } fifoStrobe_t;

endpackage

// File: rtl/odd_depth_afifo_sync.sv
module odd_depth_afifo_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

endmodule

// File: rtl/odd_depth_afifo_ctrl.sv
module odd_depth_afifo_ctrl
  import odd_depth_afifo_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output fifoStrobe_t       strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrFull,
  output logic              rdEmpty,
  output logic [ADDR_W:0]   wrPtrGray,
  output logic [ADDR_W:0]   rdPtrGray
);

  localparam int PW = ADDR_W + 1;

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrBinNext, wrGray, rdGraySyncW, fullMatch;
  logic          memWrite;

  assign wrBinNext = wrBin + PW'(1);
  // The core is full when the pointers differ only in the two top Gray bits.
  assign fullMatch = {~rdGraySyncW[PW-1:PW-2], rdGraySyncW[PW-3:0]};
  assign wrFull    = (wrGray == fullMatch);
  assign memWrite  = wrEn & ~wrFull;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (memWrite) begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  odd_depth_afifo_sync #(.W(PW)) u_rdToWr (
    .clk (wrClk),
    .rstN(wrRstN),
    .d   (rdGray),
    .q   (rdGraySyncW)
  );

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdBinNext, rdGray, wrGraySyncR;
  logic          coreEmpty, holdValid, pop, holdLoad;

  assign rdBinNext = rdBin + PW'(1);
  assign coreEmpty = (rdGray == wrGraySyncR);
  assign pop       = rdEn & holdValid;
  assign holdLoad  = ~coreEmpty & (~holdValid | pop);
  assign rdEmpty   = ~holdValid;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin     <= '0;
      rdGray    <= '0;
      holdValid <= 1'b0;
    end else begin
      if (holdLoad) begin
        rdBin  <= rdBinNext;
        rdGray <= rdBinNext ^ (rdBinNext >> 1);
      end
      if (holdLoad)  holdValid <= 1'b1;
      else if (pop)  holdValid <= 1'b0;
    end
  end

  odd_depth_afifo_sync #(.W(PW)) u_wrToRd (
    .clk (rdClk),
    .rstN(rdRstN),
    .d   (wrGray),
    .q   (wrGraySyncR)
  );

  // ---------------- outputs ----------------
  assign strb.memWrite = memWrite;
  assign strb.holdLoad = holdLoad;
  assign wrAddr        = wrBin[ADDR_W-1:0];
  assign rdAddr        = rdBin[ADDR_W-1:0];
  assign wrPtrGray     = wrGray;
  assign rdPtrGray     = rdGray;

endmodule

// File: rtl/odd_depth_afifo_dp.sv
module odd_depth_afifo_dp
  import odd_depth_afifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  fifoStrobe_t       strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] coreMem [DEPTH];
  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge wrClk) begin
    if (strb.memWrite) coreMem[wrAddr] <= wrData;
  end

  // The word at rdAddr is stable here: its write was seen through the synchronizer.
  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)            holdReg <= '0;
    else if (strb.holdLoad) holdReg <= coreMem[rdAddr];
  end

  assign rdData = holdReg;

endmodule

// File: rtl/odd_depth_afifo.sv
module odd_depth_afifo
  import odd_depth_afifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty
);

  fifoStrobe_t       strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [ADDR_W:0]   wrPtrGray, rdPtrGray;

  odd_depth_afifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrClk    (wrClk),
    .wrRstN   (wrRstN),
    .wrEn     (wrEn),
    .rdClk    (rdClk),
    .rdRstN   (rdRstN),
    .rdEn     (rdEn),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .wrFull   (wrFull),
    .rdEmpty  (rdEmpty),
    .wrPtrGray(wrPtrGray),
    .rdPtrGray(rdPtrGray)
  );

  odd_depth_afifo_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rdRstN(rdRstN),
    .strb  (strb),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .wrData(wrData),
    .rdData(rdData)
  );

endmodule

// File: rtl/odd_depth_afifo_chk.sv
module odd_depth_afifo_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input logic              wrClk,
  input logic              wrRstN,
  input logic              wrEn,
  input logic              wrFull,
  input logic              rdClk,
  input logic              rdRstN,
  input logic              rdEn,
  input logic              rdEmpty,
  input logic [DATA_W-1:0] rdData,
  input logic [PTR_W-1:0]  wrPtrGray,
  input logic [PTR_W-1:0]  rdPtrGray
);

  // R3: a refused write leaves the write pointer in place
  p_full_write_ignored_r3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrEn && wrFull) |=> $stable(wrPtrGray));

  // R7: crossing pointers move one Gray step at a time
  p_wr_gray_step_r7: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(wrPtrGray ^ $past(wrPtrGray)) <= 1);

  p_rd_gray_step_r7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(rdPtrGray ^ $past(rdPtrGray)) <= 1);

  // R6: the word on show stays put until it is read
  p_hold_stable_r6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (!rdEmpty && !rdEn) |=> (!rdEmpty && $stable(rdData)));

  // R4: empty rises only through a read
  p_empty_by_read_r4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $rose(rdEmpty) |-> $past(rdEn));

  // R1: full rises only through a write
  p_full_by_write_r1: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $rose(wrFull) |-> $past(wrEn));

endmodule

bind odd_depth_afifo odd_depth_afifo_chk #(.DATA_W(DATA_W), .PTR_W(ADDR_W + 1)) u_chk (
  .wrClk    (wrClk),
  .wrRstN   (wrRstN),
  .wrEn     (wrEn),
  .wrFull   (wrFull),
  .rdClk    (rdClk),
  .rdRstN   (rdRstN),
  .rdEn     (rdEn),
  .rdEmpty  (rdEmpty),
  .rdData   (rdData),
  .wrPtrGray(wrPtrGray),
  .rdPtrGray(rdPtrGray)
);

// File: tb/test_odd_depth_afifo.sv
`timescale 1ns/1ps
module test_odd_depth_afifo;

  localparam int DW  = 8;
  localparam int CAP = 33;

  logic          wrClk = 1'b0, rdClk = 1'b0;
  logic          wrRstN = 1'b0, rdRstN = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          wrFull, rdEmpty;

  always #2.5  wrClk = ~wrClk;   // 200 MHz
  always #3.65 rdClk = ~rdClk;   // unrelated read clock

  odd_depth_afifo #(.DATA_W(DW), .ADDR_W(5)) i_odd_depth_afifo (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData), .wrFull(wrFull),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData), .rdEmpty(rdEmpty)
  );

  logic [DW-1:0] refQ[$];
  int  errors = 0, checks = 0;
  bit  prevHeld = 1'b0;
  logic [DW-1:0] prevData = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One write-clock cycle: check at the falling edge, then drive.
  task automatic wrCycle(input bit want, input logic [DW-1:0] d, output bit acc);
    @(negedge wrClk);
    if (refQ.size() >= CAP) chk(wrFull == 1'b1, "R7 full with 33 held", wrFull, 1);
    acc    = want && !wrFull;
    wrEn   = want;
    wrData = d;
    if (acc) refQ.push_back(d);
  endtask

  // One read-clock cycle: check the shown word, then drive.
  task automatic rdCycle(input bit want);
    @(negedge rdClk);
    if (!rdEmpty) begin
      chk(refQ.size() > 0, "R7 empty not released early", refQ.size(), 1);
      if (refQ.size() > 0) chk(rdData == refQ[0], "R2 R6 oldest word shown", rdData, refQ[0]);
    end else begin
      chk(1'b1, "R7 empty", 1, 1);
    end
    if (prevHeld) begin
      chk(!rdEmpty, "R6 held word stays", rdEmpty, 0);
      chk(rdData == prevData, "R6 data stable", rdData, prevData);
    end
    prevHeld = !rdEmpty && !want;
    prevData = rdData;
    rdEn = want;
    if (want && !rdEmpty) void'(refQ.pop_front());
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit acc;
    int accepted;
    #23;
    wrRstN = 1'b1;
    rdRstN = 1'b1;

    // R5: reset state
    @(negedge wrClk);
    chk(wrFull == 1'b0, "R5 full after reset", wrFull, 0);
    @(negedge rdClk);
    chk(rdEmpty == 1'b1, "R5 empty after reset", rdEmpty, 1);

    // R1: fill with no reads
    accepted = 0;
    wrCycle(1'b1, 8'hA0, acc); accepted += int'(acc);
    for (int i = 0; i < 20; i++) wrCycle(1'b0, 8'h00, acc);
    for (int i = 0; i < 32; i++) begin
      wrCycle(1'b1, 8'(8'hA1 + i), acc);
      accepted += int'(acc);
    end
    // R3: writes while full are refused
    for (int i = 0; i < 3; i++) begin
      wrCycle(1'b1, 8'hEE, acc);
      accepted += int'(acc);
    end
    wrCycle(1'b0, 8'h00, acc);
    chk(accepted == CAP, "R1 writes accepted", accepted, CAP);
    // R8: full holds with no reads
    for (int i = 0; i < 20; i++) wrCycle(1'b0, 8'h00, acc);
    chk(wrFull == 1'b1, "R8 full stays set", wrFull, 1);

    // R2 R3: drain, checking order; no 0xEE may appear
    for (int i = 0; i < CAP + 6; i++) rdCycle(1'b1);
    rdCycle(1'b0);
    chk(refQ.size() == 0, "R3 nothing extra stored", refQ.size(), 0);
    chk(rdEmpty == 1'b1, "R7 empty after drain", rdEmpty, 1);

    // R4: reads while empty are ignored
    for (int i = 0; i < 8; i++) rdCycle(1'b1);
    rdCycle(1'b0);
    wrCycle(1'b1, 8'h5A, acc);
    wrCycle(1'b0, 8'h00, acc);
    for (int i = 0; i < 10; i++) rdCycle(1'b0);
    chk(!rdEmpty, "R4 word arrives after empty reads", rdEmpty, 0);
    chk(rdData == 8'h5A, "R4 next word delivered", rdData, 8'h5A);
    rdCycle(1'b1);
    for (int i = 0; i < 3; i++) rdCycle(1'b0);
    chk(rdEmpty == 1'b1, "R7 empty after last read", rdEmpty, 1);

    // R2: random strobes, two rate mixes
    for (int phase = 0; phase < 2; phase++) begin
      fork
        begin
          bit a;
          for (int i = 0; i < 2000; i++)
            wrCycle(($urandom % 100) < (phase == 0 ? 80 : 30), 8'($urandom), a);
          wrCycle(1'b0, 8'h00, a);
        end
        begin
          for (int i = 0; i < 1400; i++)
            rdCycle(($urandom % 100) < (phase == 0 ? 35 : 85));
          rdCycle(1'b0);
        end
      join
    end
    for (int i = 0; i < 100; i++) rdCycle(1'b1);
    rdCycle(1'b0);
    chk(refQ.size() == 0, "R2 every word delivered", refQ.size(), 0);
    chk(rdEmpty == 1'b1, "R7 empty at end", rdEmpty, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule